// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits behind the command decoder of a serial flash device and rules on every instruction the decoder presents. It keeps the write-enable latch, a status-lock bit, a top/bottom select bit and a two-bit protected-region size. It also tracks a power-down state and a busy flag that covers the program/erase engine. For each instruction strobe it answers with a one-cycle accept or reject pulse. Instructions that it does not recognize, or that arrive during power-down, get neither pulse.

A supply-good input acts as a reset. While it is low, nothing is recognized. After it rises, a lockout counter keeps all write-class instructions out for a parameterized number of cycles. Write-class instructions are rejected unless the latch has been set first. The latch clears on its own when the engine signals completion of the program, erase or status write it was running. Status writes can be locked by the hardware protect pin once the status-lock bit is set.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While `rst` is high or `supply_ok` is low, the next clock edge clears `wel`, `stat_lock`, `stat_tb`, `stat_bp`, `busy`, `pd_state`, `acc_pulse` and `rej_pulse`, and no instruction is recognized.
- R2: During the first LOCK_CYC clock cycles after the last reset cycle, Write Enable (06h), Write Status (01h), Page Program (02h), Sector Erase (20h), Block Erase (D8h) and Chip Erase (C7h) are rejected. Write Disable (04h) and Power-down (B9h) are still accepted in that window.
- R3: An accepted Write Enable (06h) sets `wel`, and an accepted Write Disable (04h) clears it. `wel` never rises without an accept pulse in the same cycle.
- R4: Write Status, Page Program, Sector Erase, Block Erase and Chip Erase are rejected when `wel` is 0.
- R5: An accepted Write Status, program or erase raises `busy`. `op_done` while `busy` is high clears both `busy` and `wel` at the next edge. `op_done` while idle has no effect.
- R6: An accepted Write Status (01h) loads `cmd_wdata`, with bit 3 going to `stat_lock`, bit 2 to `stat_tb` and bits 1:0 to `stat_bp`.
- R7: Write Status is rejected when `stat_lock` is 1 and `wp_n` is 0. When `stat_lock` is 0, `wp_n` has no effect.
- R8: The protected region depends on `stat_bp`. A value of 0 protects nothing. A value of 1 protects one quarter of the address space and 2 protects one half; the region starts at the top when `stat_tb` is 0 and at the bottom when it is 1. A value of 3 protects everything. Program and erase to a protected address are rejected, and `wel` stays set.
- R9: Chip Erase (C7h) is rejected whenever `stat_bp` is not 0.
- R10: Power-down (B9h) sets `pd_state`. While it is set, every instruction except Release (ABh) is ignored: no pulse and no state change. Release clears `pd_state` and is accepted. Outside power-down, Release is accepted with no effect.
- R11: While `busy` is high, every recognized instruction is rejected. This includes one that arrives in the same cycle as `op_done`.
- R12: Opcodes outside the nine listed (06h, 04h, 01h, 02h, 20h, D8h, C7h, B9h, ABh) produce no pulse and change no state.
- R13: Every accepted instruction gives `acc_pulse` and every rejected one gives `rej_pulse`, one cycle after the strobe. The two are never high together, and neither is high after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above write-inhibit threshold; low acts as reset |
| cmd_valid | input | 1 | One-cycle decoded instruction strobe |
| cmd_op | input | 8 | Instruction opcode |
| cmd_addr | input | ADDR_W | Target byte address for program/erase |
| cmd_wdata | input | 4 | Status write data {lock, tb, bp[1:0]} |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| op_done | input | 1 | Completion pulse from the program/erase engine |
| acc_pulse | output | 1 | Instruction accepted |
| rej_pulse | output | 1 | Instruction rejected |
| busy | output | 1 | Program/erase/status write in progress |
| wel | output | 1 | Write-enable latch |
| stat_lock | output | 1 | Status-lock bit |
| stat_tb | output | 1 | Protected region at bottom (1) or top (0) |
| stat_bp | output | 2 | Protected region size code |
| pd_state | output | 1 | Power-down state |

## Verification
The completion pulse and a new instruction can land in the same cycle. When they do, the instruction must be judged against the busy state before the edge, so it is rejected, while `wel` and `busy` both clear. The bench drives `op_done` together with a Write Enable strobe in a directed case. It also fires `op_done` at random while commands keep arriving. A bench model that updates state in the same order predicts the pulses, the latch and the busy flag for every such cycle. A second collision comes from lockout expiry meeting a Write Enable, and the reset-then-random sequences reach it.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SERA  = 8'h20;
  localparam logic [7:0] OP_BERA  = 8'hD8;
  localparam logic [7:0] OP_CERA  = 8'hC7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_WREN,
    CL_WRDI,
    CL_WRSR,
    CL_ADDRW,
    CL_CHIP,
    CL_SLEEP,
    CL_WAKE
  } cmd_cls_e;
endpackage

// File: rtl/fwp_decode.sv
module fwp_decode
  import fwp_pkg::*;
(
  input  logic [7:0] op,
  output cmd_cls_e   cls,
  output logic       wr_class
);
  always_comb begin
    case (op)
      OP_WREN:                   cls = CL_WREN;
      OP_WRDI:                   cls = CL_WRDI;
      OP_WRSR:                   cls = CL_WRSR;
      OP_PROG, OP_SERA, OP_BERA: cls = CL_ADDRW;
      OP_CERA:                   cls = CL_CHIP;
      OP_SLEEP:                  cls = CL_SLEEP;
      OP_WAKE:                   cls = CL_WAKE;
      default:                   cls = CL_NONE;
    endcase
  end

  // classes held back by the power-up lockout
  assign wr_class = (cls == CL_WREN) || (cls == CL_WRSR) ||
                    (cls == CL_ADDRW) || (cls == CL_CHIP);
endmodule

// File: rtl/fwp_lockout.sv
module fwp_lockout #(
  parameter int LOCK_CYC = 4096
) (
  input  logic clk,
  input  logic clr,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= CNT_W'(LOCK_CYC);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign locked = (cnt != '0);
endmodule

// File: rtl/fwp_region.sv
module fwp_region #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              tb,
  input  logic [1:0]        bp,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] QTR  = ADDR_W'(1) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] TOPQ = HALF + QTR;

  always_comb begin
    case (bp)
      2'd0:    hit = 1'b0;
      2'd1:    hit = tb ? (addr < QTR)  : (addr >= TOPQ);
      2'd2:    hit = tb ? (addr < HALF) : (addr >= HALF);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LOCK_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              acc_pulse,
  output logic              rej_pulse,
  output logic              busy,
  output logic              wel,
  output logic              stat_lock,
  output logic              stat_tb,
  output logic [1:0]        stat_bp,
  output logic              pd_state
);
  logic     hold_rst;
  cmd_cls_e cls;
  logic     wr_class;
  logic     locked;
  logic     hit;

  assign hold_rst = rst || !supply_ok;

  fwp_decode u_dec (
    .op       (cmd_op),
    .cls      (cls),
    .wr_class (wr_class)
  );

  fwp_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .clr    (hold_rst),
    .locked (locked)
  );

  fwp_region #(.ADDR_W(ADDR_W)) u_reg (
    .addr (cmd_addr),
    .tb   (stat_tb),
    .bp   (stat_bp),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (hold_rst) begin
      acc_pulse <= 1'b0;
      rej_pulse <= 1'b0;
      busy      <= 1'b0;
      wel       <= 1'b0;
      stat_lock <= 1'b0;
      stat_tb   <= 1'b0;
      stat_bp   <= 2'd0;
      pd_state  <= 1'b0;
    end else begin
      acc_pulse <= 1'b0;
      rej_pulse <= 1'b0;
      if (op_done && busy) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
      if (cmd_valid) begin
        if (pd_state) begin
          if (cls == CL_WAKE) begin
            pd_state  <= 1'b0;
            acc_pulse <= 1'b1;
          end
        end else if (cls != CL_NONE) begin
          // decisions use the state held before this edge
          if (busy || (locked && wr_class)) begin
            rej_pulse <= 1'b1;
          end else begin
            case (cls)
              CL_WREN: begin
                wel       <= 1'b1;
                acc_pulse <= 1'b1;
              end
              CL_WRDI: begin
                wel       <= 1'b0;
                acc_pulse <= 1'b1;
              end
              CL_WRSR: begin
                if (!wel || (stat_lock && !wp_n)) begin
                  rej_pulse <= 1'b1;
                end else begin
                  stat_lock <= cmd_wdata[3];
                  stat_tb   <= cmd_wdata[2];
                  stat_bp   <= cmd_wdata[1:0];
                  busy      <= 1'b1;
                  acc_pulse <= 1'b1;
                end
              end
              CL_ADDRW: begin
                if (!wel || hit) begin
                  rej_pulse <= 1'b1;
                end else begin
                  busy      <= 1'b1;
                  acc_pulse <= 1'b1;
                end
              end
              CL_CHIP: begin
                if (!wel || (stat_bp != 2'd0)) begin
                  rej_pulse <= 1'b1;
                end else begin
                  busy      <= 1'b1;
                  acc_pulse <= 1'b1;
                end
              end
              CL_SLEEP: begin
                pd_state  <= 1'b1;
                acc_pulse <= 1'b1;
              end
              default: acc_pulse <= 1'b1;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       acc_pulse,
  input logic       rej_pulse,
  input logic       busy,
  input logic       wel,
  input logic       pd_state
);
  // R13
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    !(acc_pulse && rej_pulse));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    !cmd_valid |=> (!acc_pulse && !rej_pulse));

  // R1
  supply_rst_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!wel && !busy && !pd_state && !acc_pulse && !rej_pulse));

  // R3
  wel_rise_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    $rose(wel) |-> acc_pulse);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    $fell(busy) |-> !wel);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    $rose(busy) |-> acc_pulse);

  // R10
  pd_ignore_chk: assert property (@(posedge clk) disable iff (rst || !supply_ok)
    (pd_state && cmd_valid && cmd_op != 8'hAB) |=> (!acc_pulse && !rej_pulse && pd_state));
endmodule

bind flash_wp_ctrl fwp_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .acc_pulse (acc_pulse),
  .rej_pulse (rej_pulse),
  .busy      (busy),
  .wel       (wel),
  .pd_state  (pd_state)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
  localparam int AW   = 17;
  localparam int LOCK = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, supply_ok = 1'b1, cmd_valid = 1'b0, wp_n = 1'b1, op_done = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0]    cmd_wdata = 4'h0;
  logic          acc_pulse, rej_pulse, busy, wel, stat_lock, stat_tb, pd_state;
  logic [1:0]    stat_bp;

  flash_wp_ctrl #(.ADDR_W(AW), .LOCK_CYC(LOCK)) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .op_done(op_done), .acc_pulse(acc_pulse), .rej_pulse(rej_pulse), .busy(busy),
    .wel(wel), .stat_lock(stat_lock), .stat_tb(stat_tb), .stat_bp(stat_bp),
    .pd_state(pd_state));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  bit m_wel, m_lock, m_tb, m_pd, m_busy, e_acc, e_rej;
  bit [1:0] m_bp;
  int m_cnt;

  function automatic bit in_prot(bit tbv, bit [1:0] bpv, logic [AW-1:0] a);
    case (bpv)
      2'd0: return 1'b0;
      2'd1: return tbv ? (a[AW-1:AW-2] == 2'b00) : (a[AW-1:AW-2] == 2'b11);
      2'd2: return tbv ? (a[AW-1] == 1'b0) : (a[AW-1] == 1'b1);
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit known(bit [7:0] op);
    return op inside {8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'hB9, 8'hAB};
  endfunction

  function automatic bit write_class(bit [7:0] op);
    return op inside {8'h06, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7};
  endfunction

  task automatic model(bit r, bit sup, bit v, bit [7:0] op, logic [AW-1:0] a,
                       bit [3:0] wd, bit wpn, bit done);
    bit pb, lk;
    e_acc = 0; e_rej = 0;
    if (r || !sup) begin
      m_wel = 0; m_lock = 0; m_tb = 0; m_bp = 0; m_pd = 0; m_busy = 0;
      m_cnt = LOCK;
      return;
    end
    pb = m_busy;
    lk = (m_cnt != 0);
    if (lk) m_cnt--;
    if (done && pb) begin m_busy = 0; m_wel = 0; end
    if (!v) return;
    if (m_pd) begin
      if (op == 8'hAB) begin m_pd = 0; e_acc = 1; end
      return;
    end
    if (!known(op)) return;
    if (pb || (lk && write_class(op))) begin e_rej = 1; return; end
    case (op)
      8'h06: begin m_wel = 1; e_acc = 1; end
      8'h04: begin m_wel = 0; e_acc = 1; end
      8'h01: if (!m_wel || (m_lock && !wpn)) e_rej = 1;
             else begin
               m_lock = wd[3]; m_tb = wd[2]; m_bp = wd[1:0]; m_busy = 1; e_acc = 1;
             end
      8'h02, 8'h20, 8'hD8:
             if (!m_wel || in_prot(m_tb, m_bp, a)) e_rej = 1;
             else begin m_busy = 1; e_acc = 1; end
      8'hC7: if (!m_wel || m_bp != 0) e_rej = 1;
             else begin m_busy = 1; e_acc = 1; end
      8'hB9: begin m_pd = 1; e_acc = 1; end
      default: e_acc = 1;
    endcase
  endtask

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit v, bit [7:0] op, logic [AW-1:0] a, bit [3:0] wd,
                     bit wpn, bit done, bit sup, bit r);
    @(negedge clk);
    rst = r; supply_ok = sup; cmd_valid = v; cmd_op = op; cmd_addr = a;
    cmd_wdata = wd; wp_n = wpn; op_done = done;
    model(r, sup, v, op, a, wd, wpn, done);
    @(posedge clk);
    #1;
    check(tag, "acc_pulse", acc_pulse, e_acc);
    check(tag, "rej_pulse", rej_pulse, e_rej);
    check(tag, "wel", wel, m_wel);
    check(tag, "busy", busy, m_busy);
    check(tag, "pd_state", pd_state, m_pd);
    check(tag, "status", {stat_lock, stat_tb, stat_bp}, {m_lock, m_tb, m_bp});
  endtask

  task automatic cmd(string tag, bit [7:0] op, logic [AW-1:0] a = '0, bit [3:0] wd = 0,
                     bit wpn = 1, bit done = 0);
    cyc(tag, 1, op, a, wd, wpn, done, 1, 0);
  endtask

  task automatic idle(string tag, bit done = 0, bit sup = 1, bit r = 0);
    cyc(tag, 0, 8'h00, '0, 0, 1, done, sup, r);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] ops [10] = '{8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'hB9, 8'hAB, 8'h03};
    void'($urandom(32'd1234));
    // R1 reset state
    for (int i = 0; i < 3; i++) idle("R1", 0, 1, 1);
    // R2 lockout: WREN refused, WRDI allowed
    cmd("R2", 8'h06);
    cmd("R3", 8'h04);
    cmd("R2", 8'h01, '0, 4'h0);
    for (int i = 0; i < LOCK; i++) idle("R2");
    // R4 no latch
    cmd("R4", 8'h02, 17'h00100);
    cmd("R4", 8'hC7);
    cmd("R3", 8'h06);
    cmd("R3", 8'h04);
    cmd("R3", 8'h06);
    // R6 status write: lock=1 tb=1 bp=01
    cmd("R6", 8'h01, '0, 4'b1101);
    idle("R5");
    // R11 collision with completion
    cmd("R11", 8'h06, '0, 0, 1, 1);
    idle("R5", 1);
    // R7 pin lock
    cmd("R3", 8'h06);
    cmd("R7", 8'h01, '0, 4'b0010, 0);
    // R8 bottom quarter protected
    cmd("R8", 8'h02, 17'h00010);
    cmd("R8", 8'h20, 17'h08000);
    idle("R5", 1);
    cmd("R3", 8'h06);
    cmd("R7", 8'h01, '0, 4'b0010, 1);
    cmd("R5", 8'h06, '0, 0, 1, 1);
    // R8 top half protected
    cmd("R3", 8'h06);
    cmd("R8", 8'hD8, 17'h10000);
    cmd("R8", 8'h02, 17'h0FFFF);
    cmd("R11", 8'h02, 17'h00000);
    idle("R5", 1);
    cmd("R3", 8'h06);
    cmd("R9", 8'hC7);
    // R7 pin ignored with lock clear
    cmd("R7", 8'h01, '0, 4'b0000, 0);
    idle("R5", 1);
    cmd("R3", 8'h06);
    cmd("R9", 8'hC7);
    idle("R5", 1);
    idle("R5", 1);
    // R12 unknown opcodes
    cmd("R3", 8'h06);
    cmd("R12", 8'h03);
    cmd("R12", 8'hFF);
    // R10 power-down
    cmd("R10", 8'hAB);
    cmd("R10", 8'hB9);
    cmd("R10", 8'h04);
    cmd("R10", 8'h01, '0, 4'b1111);
    cmd("R10", 8'hB9);
    cmd("R10", 8'hAB);
    // R1 supply drop
    idle("R1", 0, 0, 0);
    idle("R1", 0, 0, 0);
    cmd("R2", 8'h06);
    for (int i = 0; i < LOCK; i++) idle("R2");
    // R13 random traffic
    for (int i = 0; i < 6000; i++) begin
      bit v    = ($urandom % 10) < 7;
      bit [7:0] op = ops[$urandom % 10];
      bit wpn  = ($urandom % 4) != 0;
      bit dn   = ($urandom % 10) < 3;
      bit sup  = ($urandom % 300) != 0;
      cyc("R13", v, op, AW'($urandom), 4'($urandom), wpn, dn, sup, 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule